// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it waits a programmable power-up pause. It then runs a fixed burst of warm-up refresh cycles and only afterwards raises `ready`. From then on a free-running interval timer marks a refresh as due often enough to sweep every row within the retention window. Each refresh is a CAS-before-RAS cycle, so the DRAM's internal row counter picks the row, and no address is produced here.

The sequencer shares the strobes with an access controller through a request/grant pair. It raises `req`, waits for `gnt`, and drives RAS and both byte CAS strobes only while it holds the bus. A refresh that falls due while the grant is withheld is counted and kept pending, and `req` stays high. The pending count saturates at a parameter, and a further due refresh sets a sticky error flag.

A sleep request moves the DRAM into self refresh. The sequencer opens a CAS-before-RAS cycle and keeps RAS low for at least the self-refresh entry time. It then holds RAS low for as long as sleep is requested. On exit it enforces a long RAS precharge before it hands the bus back. All timings are cycle counts of the block clock.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, `req` stays low and all strobes stay high for `PWRUP_CYCLES` clock edges, and `req` first reads high after edge number `PWRUP_CYCLES`.
- R2: After the pause, exactly `INIT_CYCLES` refresh cycles run back to back under a single grant, and then `ready` rises. `sleep_req` has no effect until `ready` has risen.
- R3: In every refresh cycle both CAS strobes fall together `CSR_CYCLES` cycles before RAS falls. In a normal refresh, RAS and both CAS then stay low for `RASL_CYCLES` cycles and rise together. `ucas_n` equals `lcas_n` at all times.
- R4: Between two refresh cycles inside one grant, RAS is high for exactly `RP_CYCLES + CSR_CYCLES` cycles. Strobes go low only while `req` is high and `gnt` is held.
- R5: Once `ready` is high, a refresh falls due every `INTERVAL_CYCLES` cycles. With a constant grant latency, successive periodic RAS falls are exactly `INTERVAL_CYCLES` apart.
- R6: While `gnt` is withheld, `req` stays high and RAS stays high. After the grant returns, one refresh is issued per pending due event.
- R7: The pending count never exceeds `DEBT_LIMIT`. A due event that arrives when the count is already at the limit sets `overdue_err`, which stays set until reset.
- R8: When `sleep_req` is high in the ready idle state, a CAS-before-RAS entry is made. RAS then stays low for at least `SELF_CYCLES` cycles, and for as long as `sleep_req` stays high. Both CAS strobes return high once the minimum has elapsed. If `sleep_req` is already low, RAS is low for exactly `SELF_CYCLES` cycles.
- R9: RAS rises on the first edge after `sleep_req` is seen low (once the minimum has elapsed). It then stays high, and `ready` returns exactly `RPS_CYCLES` cycles after RAS rose.
- R10: `ready` is low from the edge on which RAS falls for self refresh until the exit precharge has completed.
- R11: During reset, RAS and both CAS are high, and `req`, `ready` and `overdue_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timings count its rising edges |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter and hold self refresh |
| gnt | input | 1 | Bus grant from the access controller |
| req | output | 1 | Bus request; high while the sequencer needs or holds the strobes |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| ready | output | 1 | DRAM initialised and not in self refresh |
| overdue_err | output | 1 | Sticky flag: a due refresh arrived with the pending count full |

## Verification
On every cycle, the assertions guard several local properties: the CAS-before-RAS order of each RAS fall, that strobes are low only while the request is held, that the request persists while the grant is withheld, that the pending count stays within its cap and the error flag stays set, and that `ready` stays low in the self-refresh states. Only the bench scenarios can show the cycle-exact figures: the length of the power-up pause, the count of warm-up cycles, the spacing of periodic refreshes, the size of the burst that follows a withheld grant, and the precharge length after self-refresh exit. Each of these spans many cycles and depends on the grant pattern.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_REQ,
    ST_CSR,
    ST_RASL,
    ST_PRE,
    ST_SELF,
    ST_SLEEP,
    ST_SREXIT
  } seq_state_t;

  typedef enum logic [1:0] {
    K_INIT,
    K_PERIODIC,
    K_SELF
  } ref_kind_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int INTERVAL_CYCLES = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int TW = (INTERVAL_CYCLES > 1) ? $clog2(INTERVAL_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);

  // R5
  interval_range_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));

endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
  parameter int DEBT_LIMIT = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic served,
  input  logic clr,
  output logic has_work,
  output logic err
);
  localparam int PW = $clog2(DEBT_LIMIT + 1);
  localparam logic [PW-1:0] CAP = PW'(DEBT_LIMIT);

  logic [PW-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      err  <= 1'b0;
    end else if (clr) begin
      pend <= '0;
    end else begin
      case ({tick, served})
        2'b10: begin
          if (pend == CAP) err <= 1'b1;
          else pend <= pend + 1'b1;
        end
        2'b01: if (pend != '0) pend <= pend - 1'b1;
        default: ;
      endcase
    end
  end

  assign has_work = (pend != '0);

  // R7
  pend_cap_chk: assert property (@(posedge clk) disable iff (rst)
    pend <= CAP);

  // R7
  err_stick_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> ($past(tick) && $past(pend) == CAP));

endmodule

// File: rtl/cbr_fsm.sv
module cbr_fsm
  import dram_ref_pkg::*;
#(
  parameter int PWRUP_CYCLES = 20000,
  parameter int INIT_CYCLES  = 8,
  parameter int CSR_CYCLES   = 1,
  parameter int RASL_CYCLES  = 5,
  parameter int RP_CYCLES    = 5,
  parameter int SELF_CYCLES  = 10001,
  parameter int RPS_CYCLES   = 7,
  parameter int LANES        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gnt,
  input  logic             sleep_req,
  input  logic             has_work,
  output logic             served,
  output logic             self_enter,
  output logic             req,
  output logic             ras_n,
  output logic [LANES-1:0] cas_n,
  output logic             ready
);
  localparam int MAXC = max2(max2(max2(PWRUP_CYCLES, SELF_CYCLES), max2(CSR_CYCLES, RASL_CYCLES)),
                             max2(RP_CYCLES, RPS_CYCLES));
  localparam int CW = $clog2(MAXC + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  seq_state_t      state, nxt;
  ref_kind_t       kind, kind_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [IW-1:0]   init_left, init_n;
  logic            ready_q, ready_n;
  logic            ras_q, req_q;
  logic [LANES-1:0] cas_q;

  always_comb begin
    nxt        = state;
    kind_n     = kind;
    init_n     = init_left;
    ready_n    = ready_q;
    served     = 1'b0;
    self_enter = 1'b0;
    cnt_n      = (cnt != '0) ? cnt - 1'b1 : cnt;
    case (state)
      ST_PWRUP: if (cnt == '0) begin
        nxt    = ST_REQ;
        kind_n = K_INIT;
      end
      ST_IDLE: begin
        if (sleep_req) begin
          nxt    = ST_REQ;
          kind_n = K_SELF;
        end else if (has_work) begin
          nxt    = ST_REQ;
          kind_n = K_PERIODIC;
        end
      end
      ST_REQ: if (gnt) begin
        nxt    = ST_CSR;
        cnt_n  = CW'(CSR_CYCLES - 1);
        served = (kind == K_PERIODIC);
      end
      ST_CSR: if (cnt == '0) begin
        if (kind == K_SELF) begin
          nxt        = ST_SELF;
          cnt_n      = CW'(SELF_CYCLES - 1);
          self_enter = 1'b1;
          ready_n    = 1'b0;
        end else begin
          nxt   = ST_RASL;
          cnt_n = CW'(RASL_CYCLES - 1);
        end
      end
      ST_RASL: if (cnt == '0) begin
        nxt   = ST_PRE;
        cnt_n = CW'(RP_CYCLES - 1);
      end
      ST_PRE: if (cnt == '0) begin
        if (kind == K_INIT && init_left > IW'(1)) begin
          init_n = init_left - 1'b1;
          nxt    = ST_CSR;
          cnt_n  = CW'(CSR_CYCLES - 1);
        end else begin
          if (kind == K_INIT) begin
            init_n  = '0;
            ready_n = 1'b1;
          end
          nxt = ST_IDLE;
        end
      end
      ST_SELF: if (cnt == '0) begin
        if (sleep_req) nxt = ST_SLEEP;
        else begin
          nxt   = ST_SREXIT;
          cnt_n = CW'(RPS_CYCLES - 1);
        end
      end
      ST_SLEEP: if (!sleep_req) begin
        nxt   = ST_SREXIT;
        cnt_n = CW'(RPS_CYCLES - 1);
      end
      ST_SREXIT: if (cnt == '0) begin
        nxt     = ST_IDLE;
        ready_n = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PWRUP;
      kind      <= K_INIT;
      cnt       <= CW'(PWRUP_CYCLES - 1);
      init_left <= IW'(INIT_CYCLES);
      ready_q   <= 1'b0;
      ras_q     <= 1'b1;
      req_q     <= 1'b0;
    end else begin
      state     <= nxt;
      kind      <= kind_n;
      cnt       <= cnt_n;
      init_left <= init_n;
      ready_q   <= ready_n;
      ras_q     <= !(nxt inside {ST_RASL, ST_SELF, ST_SLEEP});
      req_q     <= !(nxt inside {ST_PWRUP, ST_IDLE});
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) cas_q[g] <= 1'b1;
      else cas_q[g] <= !(nxt inside {ST_CSR, ST_RASL, ST_SELF});
    end
  end

  assign req   = req_q;
  assign ras_n = ras_q;
  assign cas_n = cas_q;
  assign ready = ready_q;

  // R3
  cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_q) |-> (!cas_q[0] && !$past(cas_q[0])));

  // R4
  strobe_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!ras_q || !cas_q[0]) |-> req_q);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_q && !gnt) |=> req_q);

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && sleep_req) |=> !ras_q);

  // R10
  self_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (state inside {ST_SELF, ST_SLEEP, ST_SREXIT}) |-> !ready_q);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PWRUP_CYCLES    = 20000,
  parameter int INIT_CYCLES     = 8,
  parameter int INTERVAL_CYCLES = 1560,
  parameter int CSR_CYCLES      = 1,
  parameter int RASL_CYCLES     = 5,
  parameter int RP_CYCLES       = 5,
  parameter int SELF_CYCLES     = 10001,
  parameter int RPS_CYCLES      = 7,
  parameter int DEBT_LIMIT      = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic gnt,
  output logic req,
  output logic ras_n,
  output logic ucas_n,
  output logic lcas_n,
  output logic ready,
  output logic overdue_err
);
  localparam int LANES = 2;

  logic             tick, served, self_enter, has_work, ready_i;
  logic [LANES-1:0] cas_i;

  refresh_timer #(
    .INTERVAL_CYCLES(INTERVAL_CYCLES)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .en  (ready_i),
    .tick(tick)
  );

  refresh_debt #(
    .DEBT_LIMIT(DEBT_LIMIT)
  ) u_debt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .served  (served),
    .clr     (self_enter),
    .has_work(has_work),
    .err     (overdue_err)
  );

  cbr_fsm #(
    .PWRUP_CYCLES(PWRUP_CYCLES),
    .INIT_CYCLES (INIT_CYCLES),
    .CSR_CYCLES  (CSR_CYCLES),
    .RASL_CYCLES (RASL_CYCLES),
    .RP_CYCLES   (RP_CYCLES),
    .SELF_CYCLES (SELF_CYCLES),
    .RPS_CYCLES  (RPS_CYCLES),
    .LANES       (LANES)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .gnt       (gnt),
    .sleep_req (sleep_req),
    .has_work  (has_work),
    .served    (served),
    .self_enter(self_enter),
    .req       (req),
    .ras_n     (ras_n),
    .cas_n     (cas_i),
    .ready     (ready_i)
  );

  assign ucas_n = cas_i[1];
  assign lcas_n = cas_i[0];
  assign ready  = ready_i;

endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int P    = 40;
  localparam int INIT = 8;
  localparam int IV   = 60;
  localparam int CSR  = 2;
  localparam int RASL = 4;
  localparam int RP   = 3;
  localparam int SELF = 20;
  localparam int RPS  = 5;
  localparam int LIM  = 3;
  localparam int GD   = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic gnt = 1'b0;
  logic hold = 1'b0;
  logic req, ras_n, ucas_n, lcas_n, ready, overdue_err;

  int vectors = 0;
  int miscompares = 0;

  int cyc, first_req, falls, init_falls, last_fall, last_low_run;
  int low_run, hi_run, cas_run;
  bit ready_seen, self_expect, prev_ras;

  always #5 clk = ~clk;

  dram_refresh_seq #(
    .PWRUP_CYCLES(P), .INIT_CYCLES(INIT), .INTERVAL_CYCLES(IV),
    .CSR_CYCLES(CSR), .RASL_CYCLES(RASL), .RP_CYCLES(RP),
    .SELF_CYCLES(SELF), .RPS_CYCLES(RPS), .DEBT_LIMIT(LIM)
  ) uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .gnt(gnt), .req(req),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .ready(ready),
    .overdue_err(overdue_err)
  );

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // access controller model: grants GD cycles after request unless held off
  initial begin
    int waited;
    waited = 0;
    forever begin
      @(negedge clk);
      #1;
      if (!req) begin
        gnt = 1'b0;
        waited = 0;
      end else if (hold) begin
        gnt = 1'b0;
      end else if (waited >= GD) begin
        gnt = 1'b1;
      end else begin
        waited++;
      end
    end
  end

  // strobe monitor, samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst) begin
        cyc = 0; first_req = -1; falls = 0; init_falls = 0; last_fall = 0;
        low_run = 0; hi_run = 0; cas_run = 0; ready_seen = 0; prev_ras = 1;
      end else begin
        cyc++;
        if (ucas_n !== lcas_n) chk("R3 byte strobes equal", int'(ucas_n), int'(lcas_n));
        if (req && first_req < 0) first_req = cyc;
        if (first_req < 0 && (!ras_n || !ucas_n)) chk("R1 strobe during pause", 0, 1);
        if ((!ras_n || !ucas_n) && !gnt) chk("R4 strobe without grant", int'(gnt), 1);
        if (prev_ras && !ras_n) begin
          falls++;
          if (!ready_seen) begin
            init_falls++;
            if (init_falls > 1) chk("R4 init gap", hi_run, RP + CSR);
          end
          chk("R3 cas lead", cas_run, CSR);
          last_fall = cyc;
        end
        if (!prev_ras && ras_n) begin
          last_low_run = low_run;
          if (!self_expect) begin
            chk("R3 ras low width", low_run, RASL);
            chk("R3 cas rises with ras", int'(ucas_n), 1);
          end
        end
        low_run = ras_n ? 0 : low_run + 1;
        hi_run  = ras_n ? hi_run + 1 : 0;
        cas_run = (!ucas_n && ras_n) ? cas_run + 1 : 0;
        if (ready && !ready_seen) ready_seen = 1;
        prev_ras = ras_n;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic wait_fall(output int at);
    int n;
    n = falls;
    while (falls == n) @(negedge clk);
    at = last_fall;
  endtask

  task automatic wait_idle();
    while (req) @(negedge clk);
  endtask

  task automatic do_reset(input bit slp);
    rst = 1'b1;
    sleep_req = slp;
    self_expect = 0;
    repeat (3) @(negedge clk);
    chk("R11 ras_n", int'(ras_n), 1);
    chk("R11 ucas_n", int'(ucas_n), 1);
    chk("R11 lcas_n", int'(lcas_n), 1);
    chk("R11 req", int'(req), 0);
    chk("R11 ready", int'(ready), 0);
    chk("R11 overdue_err", int'(overdue_err), 0);
    rst = 1'b0;
    while (!ready_seen) @(negedge clk);
    chk("R1 first request edge", first_req, P);
    chk("R2 warm-up cycles", init_falls, INIT);
  endtask

  initial begin
    int t0, t1, f0, n;

    // scenario A: power-up, warm-up, periodic spacing
    do_reset(1'b0);
    wait_fall(t0);
    for (int k = 0; k < 4; k++) begin
      wait_fall(t1);
      chk("R5 refresh spacing", t1 - t0, IV);
      t0 = t1;
    end

    // scenario B: grant withheld across two due events
    wait_idle();
    hold = 1'b1;
    while (!req) @(negedge clk);
    f0 = falls;
    for (int k = 0; k < IV + 10; k++) begin
      @(negedge clk);
      if (!req) chk("R6 request held", int'(req), 1);
      if (!ras_n) chk("R6 ras idle while waiting", int'(ras_n), 1);
    end
    chk("R6 no refresh while waiting", falls - f0, 0);
    chk("R7 no error below cap", int'(overdue_err), 0);
    hold = 1'b0;
    repeat (40) @(negedge clk);
    chk("R6 deferred burst", falls - f0, 2);

    // scenario B2: overflow of the pending count
    wait_idle();
    hold = 1'b1;
    while (!req) @(negedge clk);
    repeat (LIM * IV + 10) @(negedge clk);
    chk("R7 overdue flag", int'(overdue_err), 1);
    f0 = falls;
    hold = 1'b0;
    repeat (45) @(negedge clk);
    chk("R7 saturated burst", falls - f0, LIM);
    repeat (20) @(negedge clk);
    chk("R7 flag sticky", int'(overdue_err), 1);

    // scenario C: sleep held through warm-up, then self refresh
    do_reset(1'b1);
    self_expect = 1;
    wait_fall(t0);
    @(negedge clk);
    chk("R10 ready low at entry", int'(ready), 0);
    repeat (SELF + 10) @(negedge clk);
    chk("R8 ras held low", int'(ras_n), 0);
    chk("R8 cas released", int'(ucas_n), 1);
    chk("R10 ready low in self", int'(ready), 0);
    sleep_req = 1'b0;
    @(negedge clk);
    chk("R9 ras rises on exit", int'(ras_n), 1);
    n = 0;
    while (!ready) begin
      @(negedge clk);
      n++;
      if (!ras_n) chk("R9 ras high in precharge", int'(ras_n), 1);
    end
    chk("R9 exit precharge", n, RPS);

    // scenario C2: sleep dropped at once, minimum self time applies
    wait_idle();
    sleep_req = 1'b1;
    wait_fall(t0);
    sleep_req = 1'b0;
    while (!ras_n) @(negedge clk);
    chk("R8 minimum self time", last_low_run, SELF);
    n = 0;
    while (!ready) begin
      @(negedge clk);
      n++;
    end
    chk("R9 precharge after short self", n, RPS);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule